// File: doc/BRIEF.md
# Clock-Output Enable Register Slave on a Two-Wire Bus

This block is a two-wire serial slave that keeps a small bank of 8-bit configuration registers. Each register bit drives one output-enable control of a clock device, so a clear bit turns one output off. The bank loads all ones at reset. A device that is never written therefore runs with every output on.

The master sends a command byte after the write address. The top bit of the command picks either a block transfer, which always starts at register 0, or a single-byte transfer at an indexed register. Two further bits form a chip-select field that must be zero. The low five bits hold the register index. A block write gives a byte count and then the data. A block read first returns a byte count and then the registers from the lowest upward, for as long as the master acknowledges. The bus lines are oversampled with the system clock. The slave drives SDA only through an active-low open-drain enable.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset every register holds FFh, so `out_en` is all ones. Register k appears on `out_en[8k+7:8k]`.
- R2: The slave acknowledges only the address byte D2h (write) or D3h (read), which is 7-bit address 69h. After any other address it acknowledges nothing and changes nothing until the next start.
- R3: A block write uses command 00h, then a count byte, then data bytes. The data goes to registers 0, 1, 2 in order, and every one of these bytes is acknowledged.
- R4: A single-byte write uses command 100ooooo (bit 7 = 1, bits 6:5 = 00, bits 4:0 = index), followed by one data byte. The byte is written to register `ooooo` and acknowledged.
- R5: The slave does not acknowledge a command whose bits 6:5 are nonzero, a block command (bit 7 = 0) with nonzero bits 4:0, or a single-byte index of 8 or more. No register changes in any of these cases.
- R6: In a block write, a data byte past the count or past register 7 is not acknowledged and is not written. The same holds for a second data byte in a single-byte write.
- R7: A block read uses a write of command 00h, a repeated start and address D3h. The slave returns the count 08h and then registers 0 upward. It stops sending after the master's not-acknowledge.
- R8: A single-byte read uses a write of command 100ooooo, a repeated start and address D3h. The slave returns register `ooooo`.
- R9: Bytes travel most significant bit first. The slave changes SDA only while SCL is low, and it only pulls the line low or releases it.
- R10: A stop ends the transfer at any byte boundary. Bytes of a block write that were acknowledged before the stop stay written, and later registers keep their values.
- R11: A repeated start after the command byte restarts address decoding without losing the command held by the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high the data line is pulled low; when low it is released |
| out_en | output | NUM_REGS*8 | All register bits, register k at bits 8k+7:8k |

## Verification
On one falling SCL edge the slave can both release its acknowledge and start driving the first bit of a read byte. When that bit is zero, SDA has to stay low across the handoff with no release glitch. The bench provokes this with byte reads of registers whose top bit is clear (00h, 01h, 7Fh) and with the count byte 08h. It judges the result by the byte the master collects and by a monitor that counts SDA edges during SCL high outside start and stop. In the same way, the acknowledge of a data byte and its register write fall on the same edge. The bench confirms this by reading `out_en` right after each acknowledged or refused byte.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef enum logic [2:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_WDATA,
        RL_RCNT,
        RL_RDATA
    } role_t;

    typedef struct packed {
        logic       single;
        logic [1:0] csel;
        logic [4:0] index;
    } cmd_t;

    function automatic logic cmd_ok(input cmd_t c, input int unsigned nregs);
        if (c.csel != 2'b00) return 1'b0;
        if (c.single) return (32'(c.index) < nregs);
        return (c.index == 5'd0);
    endfunction

endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m, scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
    parameter int          NUM_REGS    = 8,
    parameter int          PTR_W       = 4,
    parameter logic [7:0]  REG_DEFAULT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    localparam logic [PTR_W-1:0] IDX_END = PTR_W'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= REG_DEFAULT;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if ((rd_idx < IDX_END) && (rd_idx == PTR_W'(i))) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/cfgs_engine.sv
module cfgs_engine
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         PTR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_idx
);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(NUM_REGS);
    localparam logic [7:0]       RD_COUNT = 8'(NUM_REGS);

    phase_t           phase;
    role_t            role;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic             cmd_single;
    logic [4:0]       cmd_index;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       remain;
    logic             mack;

    logic             byte_done, in_range, wr_ok, ack_now;
    logic [7:0]       tx_byte;
    cmd_t             cmd_in;

    assign cmd_in    = cmd_t'(shreg);
    assign byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
    assign in_range  = (ptr < PTR_END);
    assign wr_ok     = (remain != 8'd0) && in_range;
    assign tx_byte   = (role == RL_RCNT) ? RD_COUNT : rd_data;

    always_comb begin
        case (role)
            RL_ADDR:  ack_now = (shreg[7:1] == DEV_ADDR);
            RL_CMD:   ack_now = cmd_ok(cmd_in, NUM_REGS);
            RL_CNT:   ack_now = 1'b1;
            RL_WDATA: ack_now = wr_ok;
            default:  ack_now = 1'b0;
        endcase
    end

    assign wr_en   = byte_done && (role == RL_WDATA) && wr_ok;
    assign wr_idx  = ptr;
    assign wr_data = shreg;
    assign rd_idx  = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            role       <= RL_ADDR;
            bitcnt     <= 4'd0;
            shreg      <= 8'h00;
            cmd_single <= 1'b0;
            cmd_index  <= 5'd0;
            ptr        <= '0;
            remain     <= 8'd0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_det) begin
            phase  <= PH_RX;
            role   <= RL_ADDR;
            bitcnt <= 4'd0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && (bitcnt != 4'd8)) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        if (ack_now) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_RX_ACK;
                            case (role)
                                RL_ADDR: begin
                                    if (shreg[0]) begin
                                        role <= cmd_single ? RL_RDATA : RL_RCNT;
                                        ptr  <= cmd_single ? PTR_W'(cmd_index) : '0;
                                    end else begin
                                        role <= RL_CMD;
                                    end
                                end
                                RL_CMD: begin
                                    cmd_single <= cmd_in.single;
                                    cmd_index  <= cmd_in.index;
                                    ptr        <= cmd_in.single ? PTR_W'(cmd_in.index) : '0;
                                    remain     <= cmd_in.single ? 8'd1 : 8'd0;
                                    role       <= cmd_in.single ? RL_WDATA : RL_CNT;
                                end
                                RL_CNT: begin
                                    remain <= shreg;
                                    role   <= RL_WDATA;
                                end
                                RL_WDATA: begin
                                    ptr    <= ptr + 1'b1;
                                    remain <= remain - 8'd1;
                                end
                                default: ;
                            endcase
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_IDLE;
                        end
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        if ((role == RL_RCNT) || (role == RL_RDATA)) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            bitcnt <= 4'd1;
                            phase  <= PH_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= 4'd0;
                            phase  <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_TX_ACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                        if (!sda_s) begin
                            if (role == RL_RCNT) role <= RL_RDATA;
                            else if (in_range)   ptr  <= ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (mack) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            bitcnt <= 4'd1;
                            phase  <= PH_TX;
                        end else begin
                            phase  <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] REG_DEFAULT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] out_en
);
    localparam int PTR_W = $clog2(NUM_REGS) + 1;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    cfgs_line_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgs_engine #(
        .NUM_REGS (NUM_REGS),
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    cfgs_regbank #(
        .NUM_REGS    (NUM_REGS),
        .PTR_W       (PTR_W),
        .REG_DEFAULT (REG_DEFAULT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (out_en)
    );

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
    parameter int         NUM_REGS    = 8,
    parameter int         PTR_W       = 4,
    parameter logic [7:0] REG_DEFAULT = 8'hFF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_s,
    input logic                  sda_oe,
    input logic                  stop_det,
    input logic                  wr_en,
    input logic [PTR_W-1:0]      wr_idx,
    input logic [NUM_REGS*8-1:0] out_en
);
    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst |=> (out_en == {NUM_REGS{REG_DEFAULT}}));

    assert_write_in_bank_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < PTR_W'(NUM_REGS)));

    assert_regs_only_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_en) |-> $past(wr_en));

    assert_drive_while_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

endmodule

bind cfg_smbus_slave cfgs_chk #(
    .NUM_REGS    (NUM_REGS),
    .PTR_W       (PTR_W),
    .REG_DEFAULT (REG_DEFAULT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .out_en   (out_en)
);

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8 * CLK_PERIOD;
    localparam int NREG       = 8;
    localparam int NVEC       = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h005A, 16'h0780, 16'h0301,
                                           16'h0500, 16'h077F, 16'h01C3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic m_cond = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] out_en;
    wire  sda_line;

    int checks = 0;
    int fails = 0;
    int bad_edges = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    assign sda_line = !(m_low || sda_oe);

    cfg_smbus_slave u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .out_en (out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(sda_line) if (!rst && scl && !m_cond) bad_edges++;

    function automatic logic [NREG*8-1:0] model_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check(out_en == model_vec(), tag, out_en, model_vec());
    endtask

    task automatic m_start();
        m_cond = 1'b1; m_low = 1'b0; scl = 1'b1; #(Q);
        m_low = 1'b1; #(Q);
        scl = 1'b0; #(Q);
        m_cond = 1'b0;
    endtask

    task automatic m_rstart();
        m_low = 1'b0; #(Q);
        m_cond = 1'b1; scl = 1'b1; #(Q);
        m_low = 1'b1; #(Q);
        scl = 1'b0; #(Q);
        m_cond = 1'b0;
    endtask

    task automatic m_stop();
        m_low = 1'b1; #(Q);
        m_cond = 1'b1; scl = 1'b1; #(Q);
        m_low = 1'b0; #(Q);
        m_cond = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; #(Q);
        scl = 1'b1; #(2*Q);
        scl = 1'b0; #(Q);
    endtask

    task automatic read_bit(output logic b);
        m_low = 1'b0; #(Q);
        scl = 1'b1; #(Q);
        b = sda_line; #(Q);
        scl = 1'b0; #(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        read_bit(x);
        acked = !x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        for (int i = 7; i >= 0; i--) read_bit(d[i]);
        send_bit(!give_ack);
        m_low = 1'b0;
    endtask

    task automatic wr_byte(input logic [4:0] idx, input logic [7:0] data, output logic [2:0] acks);
        m_start();
        send_byte(8'hD2, acks[2]);
        send_byte({3'b100, idx}, acks[1]);
        send_byte(data, acks[0]);
        m_stop();
    endtask

    task automatic rd_byte(input logic [4:0] idx, output logic [7:0] d, output logic [2:0] acks);
        m_start();
        send_byte(8'hD2, acks[2]);
        send_byte({3'b100, idx}, acks[1]);
        m_rstart();
        send_byte(8'hD3, acks[0]);
        recv_byte(d, 1'b0);
        m_stop();
    endtask

    task automatic blk_wr(input logic [7:0] cnt, input int n, input logic [7:0] base, output logic [15:0] acks);
        acks = '0;
        m_start();
        send_byte(8'hD2, acks[0]);
        send_byte(8'h00, acks[1]);
        send_byte(cnt, acks[2]);
        for (int i = 0; i < n; i++) send_byte(base + 8'(i), acks[3+i]);
        m_stop();
    endtask

    initial begin
        logic [2:0]  a3;
        logic [15:0] a16;
        logic [7:0]  d;
        logic        ak;
        for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
        #(CLK_PERIOD*6);
        rst = 1'b0;
        #(Q);

        // R1: defaults after reset
        check_regs("R1 reset defaults");
        rd_byte(5'd4, d, a3);
        check(d == 8'hFF, "R1 R8 read default", d, 8'hFF);

        // Table of single-byte writes, each read back
        for (int v = 0; v < NVEC; v++) begin
            wr_byte(VEC[v][12:8], VEC[v][7:0], a3);
            check(a3 == 3'b111, "R4 byte write acks", a3, 3'b111);
            model[VEC[v][10:8]] = VEC[v][7:0];
            check_regs("R4 byte write target");
            rd_byte(VEC[v][12:8], d, a3);
            check(a3 == 3'b111, "R8 R11 byte read acks", a3, 3'b111);
            check(d == VEC[v][7:0], "R8 R9 byte read value", d, VEC[v][7:0]);
        end

        // R2: foreign address
        m_start();
        send_byte(8'hD4, ak);
        check(!ak, "R2 foreign address nack", ak, 1'b0);
        send_byte(8'h81, ak);
        send_byte(8'h00, ak);
        m_stop();
        check_regs("R2 foreign address no change");

        // R5: rejected command codes
        m_start(); send_byte(8'hD2, ak); send_byte(8'hA1, ak);
        check(!ak, "R5 nonzero chip select nack", ak, 1'b0);
        send_byte(8'h00, ak); m_stop();
        m_start(); send_byte(8'hD2, ak); send_byte(8'h01, ak);
        check(!ak, "R5 block with index nack", ak, 1'b0);
        send_byte(8'h00, ak); m_stop();
        m_start(); send_byte(8'hD2, ak); send_byte(8'h88, ak);
        check(!ak, "R5 index out of bank nack", ak, 1'b0);
        send_byte(8'h00, ak); m_stop();
        check_regs("R5 rejected commands no change");

        // R3: block write of three bytes
        blk_wr(8'd3, 3, 8'h11, a16);
        check(a16[5:0] == 6'b111111, "R3 block write acks", a16, 16'h003F);
        for (int i = 0; i < 3; i++) model[i] = 8'h11 + 8'(i);
        check_regs("R3 block write data");

        // R6: data beyond count
        blk_wr(8'd2, 3, 8'h44, a16);
        check(a16[5:0] == 6'b011111, "R6 beyond count nack", a16, 16'h001F);
        model[0] = 8'h44; model[1] = 8'h45;
        check_regs("R6 beyond count not written");

        // R6: data beyond the last register
        blk_wr(8'd9, 9, 8'h90, a16);
        check(a16[11:0] == 12'h7FF, "R6 beyond bank nack", a16, 16'h07FF);
        for (int i = 0; i < NREG; i++) model[i] = 8'h90 + 8'(i);
        check_regs("R6 beyond bank");

        // R10: stop after a partial block
        blk_wr(8'd4, 2, 8'hA0, a16);
        check(a16[4:0] == 5'b11111, "R10 partial block acks", a16, 16'h001F);
        model[0] = 8'hA0; model[1] = 8'hA1;
        check_regs("R10 partial block kept");

        // R7: block read with count first
        m_start();
        send_byte(8'hD2, a3[2]);
        send_byte(8'h00, a3[1]);
        m_rstart();
        send_byte(8'hD3, a3[0]);
        check(a3 == 3'b111, "R7 R11 block read acks", a3, 3'b111);
        recv_byte(d, 1'b1);
        check(d == 8'(NREG), "R7 block read count", d, 8'(NREG));
        for (int i = 0; i < NREG; i++) begin
            recv_byte(d, i != NREG-1);
            check(d == model[i], "R7 block read data", d, model[i]);
        end
        m_stop();
        #(Q);
        check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 1'b0);

        // R9: no slave edges during SCL high
        check(bad_edges == 0, "R9 SDA stable while SCL high", bad_edges, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule